// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor and a main memory of 32K words of 12 bits. A 15-bit word address is split into a 9-bit set index (low bits) and a 6-bit tag (high bits). Each of the 512 sets holds two ways. A way stores a tag, one data word, a valid flag, a dirty flag and a single use bit. A use bit at 1 marks its way as the least recently used one. A request whose tag matches a valid way in the indexed set is answered in the same cycle it is presented.

When no way matches, the controller picks a victim. An empty way is taken first. Among two valid ways, the one whose use bit is 1 is taken. If the victim holds modified data, it is first written back to memory at its own address. The requested word is then read from memory. The line is refilled, the use bits are updated and the request completes. Writes follow a write-back policy: a write hit changes only the cache and marks the way dirty. A write miss fetches the word first and then overwrites it in the cache.

The processor holds `req_i`, `we_i`, `addr_i` and `wdata_i` steady until `ready_o` rises. Memory transactions use a request/acknowledge pair. `mem_req_o` stays high until `mem_ack_i` is seen. `mem_ack_i` is a one-cycle pulse, and on a read `mem_rdata_i` is valid during that pulse.

Top module: `set_assoc_cache`

## Requirements
- R1: After reset, `ready_o` and `mem_req_o` are low, every way of every set is empty, and both use bits of every set are 1.
- R2: A read miss with a clean or empty victim issues exactly one memory read (`mem_we_o`=0) at `addr_i`, then raises `ready_o` with `rdata_o` equal to the word returned by memory.
- R3: A request that matches a valid way raises `ready_o` combinationally in the cycle it is presented, returns that way's data, and starts no memory transaction.
- R4: Two addresses with the same index and different tags can be resident at the same time, and both then hit.
- R5: A hit or a refill clears the use bit of the way involved and sets the use bit of the other way to 1. On a miss with both ways valid, the way whose use bit is 1 is replaced.
- R6: An empty way is chosen as victim before any valid way. When both use bits are 1, way 0 is chosen.
- R7: A write hit updates only the cache: no memory transaction occurs, and a later read of that address returns the written value.
- R8: A write miss reads the word from memory, stores `wdata_i` in the line, marks the line dirty and does not write memory.
- R9: When the victim is valid and dirty, a memory write (`mem_we_o`=1) with the victim's tag and index as address and its data comes first. The fill read follows directly after that write's acknowledge.
- R10: A victim that is clean or empty is never written to memory.
- R11: Once raised, `mem_req_o`, `mem_we_o` and `mem_addr_o` remain steady until `mem_ack_i` is high.
- R12: `ready_o` is high only while `req_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Word address: tag in [14:9], index in [8:0] |
| wdata_i | input | 12 | Write data |
| ready_o | output | 1 | Request completes in this cycle |
| rdata_o | output | 12 | Read data, valid with `ready_o` |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | Memory transaction is a write-back |
| mem_addr_o | output | 15 | Memory word address |
| mem_wdata_o | output | 12 | Write-back data |
| mem_ack_i | input | 1 | Memory acknowledge, one-cycle pulse |
| mem_rdata_i | input | 12 | Fill data, valid with `mem_ack_i` |

## Verification
The checks assume that the processor keeps its request fields steady from the cycle `req_i` rises until `ready_o` is seen. They also assume that memory raises `mem_ack_i` only while `mem_req_o` is high, and then for one cycle only. The bench stays within these limits. Its processor task changes inputs only on the falling edge and drops `req_i` right after the completing cycle. Its memory model waits a fixed number of cycles after seeing a request, and then pulses the acknowledge once. The model also records each write-back and each fill. This lets the choice of victim, the order of write-back before fill, and whether memory was touched at all be judged from the ports alone.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 12;
  localparam int IDX_W  = 9;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int WAYS   = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2,
    ST_DONE = 2'd3
  } ctrl_state_e;
endpackage

// File: rtl/cache_ways.sv
module cache_ways #(
  parameter int SETS   = 512,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 12,
  parameter int WAYS   = 2,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic                          wr_en_i,
  input  logic [WAYS-1:0]               wr_sel_i,
  input  logic [TAG_W-1:0]              wr_tag_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          wr_dirty_i,
  output logic [WAYS-1:0][TAG_W-1:0]    tag_o,
  output logic [WAYS-1:0][DATA_W-1:0]   data_o,
  output logic [WAYS-1:0]               valid_o,
  output logic [WAYS-1:0]               dirty_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_m  [SETS];
    logic [DATA_W-1:0] data_m [SETS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic              wr_here;

    assign wr_here = wr_en_i & wr_sel_i[w];

    always_ff @(posedge clk_i) begin
      if (wr_here) begin
        tag_m[idx_i]  <= wr_tag_i;
        data_m[idx_i] <= wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (wr_here) begin
        valid_q[idx_i] <= 1'b1;
        dirty_q[idx_i] <= wr_dirty_i;
      end
    end

    assign tag_o[w]   = tag_m[idx_i];
    assign data_o[w]  = data_m[idx_i];
    assign valid_o[w] = valid_q[idx_i];
    assign dirty_o[w] = dirty_q[idx_i] & valid_q[idx_i];
  end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS  = 512,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             upd_en_i,
  input  logic             upd_way_i,
  output logic [1:0]       use_o
);
  logic [1:0] use_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) use_q[s] <= 2'b11;
    end else if (upd_en_i) begin
      // touched way becomes most recent, the other least recent
      use_q[idx_i][upd_way_i]  <= 1'b0;
      use_q[idx_i][!upd_way_i] <= 1'b1;
    end
  end

  assign use_o = use_q[idx_i];

  // R5: the state with both use bits clear never occurs
  a_r5_use_not_both_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_o != 2'b00);
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int IDX_W  = 9,
  parameter int DATA_W = 12,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic                        ready_o,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic [1:0][TAG_W-1:0]       way_tag_i,
  input  logic [1:0][DATA_W-1:0]      way_data_i,
  input  logic [1:0]                  way_valid_i,
  input  logic [1:0]                  way_dirty_i,
  input  logic [1:0]                  use_i,
  output logic                        wr_en_o,
  output logic [1:0]                  wr_sel_o,
  output logic [TAG_W-1:0]            wr_tag_o,
  output logic [DATA_W-1:0]           wr_data_o,
  output logic                        wr_dirty_o,
  output logic                        lru_en_o,
  output logic                        lru_way_o,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic [DATA_W-1:0]           mem_rdata_i
);
  ctrl_state_e       state_q, state_d;
  logic              victim_q;
  logic [DATA_W-1:0] fill_q;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [1:0]        hit_vec;
  logic              hit, hit_way, victim;
  logic [DATA_W-1:0] done_data;

  assign req_tag = addr_i[ADDR_W-1:IDX_W];
  assign req_idx = addr_i[IDX_W-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_vec[w] = way_valid_i[w] && (way_tag_i[w] == req_tag);
  end
  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];

  // empty way first, then the least recent; tie picks way 0
  always_comb begin
    if (!way_valid_i[0])      victim = 1'b0;
    else if (!way_valid_i[1]) victim = 1'b1;
    else if (use_i[0])        victim = 1'b0;
    else                      victim = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i && !hit)
                 state_d = (way_valid_i[victim] && way_dirty_i[victim]) ? ST_WB : ST_FILL;
      ST_WB:   if (mem_ack_i) state_d = ST_FILL;
      ST_FILL: if (mem_ack_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      victim_q <= 1'b0;
      fill_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) victim_q <= victim;
      if (state_q == ST_FILL && mem_ack_i) fill_q <= mem_rdata_i;
    end
  end

  assign done_data = we_i ? wdata_i : fill_q;

  always_comb begin
    ready_o    = 1'b0;
    rdata_o    = way_data_i[hit_way];
    wr_en_o    = 1'b0;
    wr_sel_o   = 2'b00;
    wr_tag_o   = req_tag;
    wr_data_o  = wdata_i;
    wr_dirty_o = 1'b1;
    lru_en_o   = 1'b0;
    lru_way_o  = hit_way;
    if (state_q == ST_IDLE && req_i && hit) begin
      ready_o  = 1'b1;
      lru_en_o = 1'b1;
      if (we_i) begin
        wr_en_o  = 1'b1;
        wr_sel_o = hit_vec;
      end
    end else if (state_q == ST_DONE) begin
      ready_o    = 1'b1;
      rdata_o    = done_data;
      wr_en_o    = 1'b1;
      wr_sel_o   = victim_q ? 2'b10 : 2'b01;
      wr_data_o  = done_data;
      wr_dirty_o = we_i;
      lru_en_o   = 1'b1;
      lru_way_o  = victim_q;
    end
  end

  assign mem_req_o   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ? {way_tag_i[victim_q], req_idx} : addr_i;
  assign mem_wdata_o = way_data_i[victim_q];

  // R11: request held steady until acknowledged
  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));
  // R9: write-back acknowledge is followed directly by the fill read
  a_r9_fill_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o));
  // R10: only a valid dirty victim is written to memory
  a_r10_wb_only_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (way_valid_i[victim_q] && way_dirty_i[victim_q]));
  // R12: completion only while a request is present
  a_r12_ready_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> req_i);
endmodule

// File: rtl/set_assoc_cache.sv
module set_assoc_cache
  import cache_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [WAYS-1:0][TAG_W-1:0]  way_tag;
  logic [WAYS-1:0][DATA_W-1:0] way_data;
  logic [WAYS-1:0]             way_valid, way_dirty, wr_sel;
  logic [1:0]                  use_bits;
  logic                        wr_en, wr_dirty, lru_en, lru_way;
  logic [TAG_W-1:0]            wr_tag;
  logic [DATA_W-1:0]           wr_data;
  logic [IDX_W-1:0]            idx;

  assign idx = addr_i[IDX_W-1:0];

  cache_ways #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W), .WAYS(WAYS)) u_ways (
    .clk_i, .rst_ni, .idx_i(idx),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_tag_i(wr_tag),
    .wr_data_i(wr_data), .wr_dirty_i(wr_dirty),
    .tag_o(way_tag), .data_o(way_data), .valid_o(way_valid), .dirty_o(way_dirty)
  );

  cache_lru #(.SETS(SETS)) u_lru (
    .clk_i, .rst_ni, .idx_i(idx),
    .upd_en_i(lru_en), .upd_way_i(lru_way), .use_o(use_bits)
  );

  cache_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ready_o, .rdata_o,
    .way_tag_i(way_tag), .way_data_i(way_data), .way_valid_i(way_valid),
    .way_dirty_i(way_dirty), .use_i(use_bits),
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_tag_o(wr_tag), .wr_data_o(wr_data),
    .wr_dirty_o(wr_dirty), .lru_en_o(lru_en), .lru_way_o(lru_way),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );
endmodule

// File: tb/set_assoc_cache_tb_top.sv
module set_assoc_cache_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic [11:0] wdata_i = '0;
  logic        ready_o;
  logic [11:0] rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [14:0] mem_addr_o;
  logic [11:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [11:0] mem_rdata_i = '0;

  int checks = 0, fails = 0;
  int wb_cnt = 0, fill_cnt = 0;
  logic [14:0] wb_addr, fill_addr;
  logic [11:0] wb_data;
  bit wb_then_fill;
  logic [11:0] mem_m [int];

  always #4 clk_i = ~clk_i;

  set_assoc_cache dut_i (.*);

  function automatic logic [11:0] model_rd(input logic [14:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return 12'((int'(a) * 7 + 3));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: acknowledge two cycles after a request is seen
  initial begin
    logic [14:0] a0;
    logic        w0;
    forever begin
      @(negedge clk_i);
      if (mem_req_o) begin
        a0 = mem_addr_o;
        w0 = mem_we_o;
        repeat (2) @(negedge clk_i);
        // R11: request fields unchanged while waiting
        check(mem_req_o && mem_addr_o == a0 && mem_we_o == w0, "R11", int'(mem_addr_o), int'(a0));
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          mem_m[int'(mem_addr_o)] = mem_wdata_o;
          wb_cnt++;
          wb_addr = mem_addr_o;
          wb_data = mem_wdata_o;
          wb_then_fill = 1'b1;
        end else begin
          mem_rdata_i = model_rd(mem_addr_o);
          fill_cnt++;
          fill_addr = mem_addr_o;
        end
        @(negedge clk_i);
        mem_ack_i = 1'b0;
        if (wb_then_fill) begin
          check(mem_req_o && !mem_we_o, "R9", {mem_req_o, mem_we_o}, 2);
          wb_then_fill = 1'b0;
        end
      end
    end
  end

  task automatic access(input logic we, input logic [14:0] a, input logic [11:0] wd,
                        output logic [11:0] rd, output bit hit);
    int cyc = 0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = wd;
    #1;
    while (!ready_o) begin
      @(negedge clk_i); #1;
      cyc++;
    end
    rd  = rdata_o;
    hit = (cyc == 0);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  // read that is expected to hit with a given value and no memory traffic
  task automatic expect_hit(input logic [14:0] a, input logic [11:0] exp, input string req);
    logic [11:0] rd; bit hit; int f0, w0;
    f0 = fill_cnt; w0 = wb_cnt;
    access(1'b0, a, '0, rd, hit);
    check(hit && fill_cnt == f0 && wb_cnt == w0, req, hit, 1);
    check(rd == exp, req, int'(rd), int'(exp));
  endtask

  // read that is expected to miss, fetch from a, and optionally write back
  task automatic expect_miss(input logic [14:0] a, input int wbs, input string req);
    logic [11:0] rd, exp; bit hit; int f0, w0;
    f0 = fill_cnt; w0 = wb_cnt;
    access(1'b0, a, '0, rd, hit);
    exp = model_rd(a);
    check(!hit && fill_cnt == f0 + 1 && fill_addr == a, req, int'(fill_addr), int'(a));
    check(wb_cnt == w0 + wbs, req, wb_cnt - w0, wbs);
    check(rd == exp, req, int'(rd), int'(exp));
  endtask

  localparam logic [14:0] A = 15'h0203, B = 15'h0403, C = 15'h0603, D = 15'h0803;
  localparam logic [14:0] E = 15'h0A10, F = 15'h0C10, G = 15'h0E10;

  task automatic t_reset;
    check(!ready_o && !mem_req_o, "R1", {ready_o, mem_req_o}, 0);
    @(negedge clk_i);
    check(!ready_o, "R12", ready_o, 0);
  endtask

  task automatic t_fill_two_ways;
    expect_miss(A, 0, "R1 R2");       // empty cache: first access misses
    expect_hit(A, model_rd(A), "R3");
    expect_miss(B, 0, "R6");          // empty way 1 taken, A stays
    expect_hit(A, model_rd(A), "R4 R6");
    expect_hit(B, model_rd(B), "R4");
  endtask

  task automatic t_lru;
    expect_hit(A, model_rd(A), "R5"); // B now least recent
    expect_miss(C, 0, "R5 R10");      // evicts clean B
    expect_hit(A, model_rd(A), "R5");
    expect_miss(B, 0, "R5");          // evicts C
    expect_hit(B, model_rd(B), "R5");
  endtask

  task automatic t_write_hit;
    logic [11:0] rd; bit hit; int f0, w0;
    f0 = fill_cnt; w0 = wb_cnt;
    access(1'b1, A, 12'hABC, rd, hit);
    check(hit && fill_cnt == f0 && wb_cnt == w0, "R7", wb_cnt - w0, 0);
    expect_hit(A, 12'hABC, "R7");
    check(model_rd(A) != 12'hABC, "R7", int'(model_rd(A)), 0);
  endtask

  task automatic t_dirty_evict;
    expect_hit(B, model_rd(B), "R5"); // A (dirty) now least recent
    expect_miss(D, 1, "R9");
    check(wb_addr == A && wb_data == 12'hABC, "R9", int'(wb_data), 12'hABC);
    expect_miss(A, 0, "R10");         // evicts clean B, returns written-back value
    expect_hit(A, 12'hABC, "R9");
  endtask

  task automatic t_write_miss;
    logic [11:0] rd; bit hit; int f0, w0;
    f0 = fill_cnt; w0 = wb_cnt;
    access(1'b1, E, 12'h123, rd, hit);
    check(!hit && fill_cnt == f0 + 1 && fill_addr == E, "R8", int'(fill_addr), int'(E));
    check(wb_cnt == w0 && !mem_m.exists(int'(E)), "R8", wb_cnt - w0, 0);
    expect_hit(E, 12'h123, "R8");
    expect_miss(F, 0, "R6");
    expect_hit(F, model_rd(F), "R5"); // E least recent
    expect_miss(G, 1, "R8 R9");
    check(wb_addr == E && wb_data == 12'h123, "R9", int'(wb_data), 12'h123);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_fill_two_ways();
    t_lru();
    t_write_hit();
    t_dirty_evict();
    t_write_miss();
    repeat (3) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    finish_run();
  end
endmodule